// File: doc/BRIEF.md
# Serial DAC Input Interface

This block is the digital front end of a 12-bit converter that is loaded over a three-wire serial link. Every pin is brought into a fast system clock domain through a synchronizer chain. Edges of the serial clock, the active-low frame strobe and the active-low load strobe are then detected on that clock. A 16-bit shift register collects a frame of 16 bits. The low 12 bits of the frame are moved into a code latch, and that latch is the only state that drives the converter code outputs.

Two loading styles are supported. In standalone use, a bit counter stops taking bits after sixteen serial clock falls, until the frame strobe is raised. In chained use there is no such limit: each bit that leaves the top of the register is driven on the serial output, so the next device in a chain can take it. The level of the load strobe when a frame starts picks the update method. If it is low, the latch loads on the sixteenth bit. If it is high, the latch loads on a later falling edge of the load strobe. An active-low clear forces the latch to zero. A coding select gives a second, straight-binary copy of the code with its top bit inverted.

Top module: `ser_dac_front`

## Requirements
- R1: After reset, `code_o` and `binary_o` are 0 and `data_o` is 0.
- R2: A frame is 16 bits, sent MSB first. Only the last 12 bits reach the latch; the first 4 bits are ignored.
- R3: With `chain_i`=0, serial clock falls after the sixteenth in a frame do not shift, so they change nothing that a later load can see.
- R4: Serial clock falls while `frame_n_i` is high do not shift the register.
- R5: If `load_n_i` is low when `frame_n_i` falls, `code_o` takes the new code after the sixteenth fall, with no activity on `load_n_i`.
- R6: If `load_n_i` is high when `frame_n_i` falls, `code_o` does not change at the end of the frame. It loads on the next falling edge of `load_n_i`.
- R7: With `chain_i`=1 there is no bit limit. Each fall moves the old register MSB onto `data_o`. A load after 32 bits takes the second word.
- R8: With `chain_i`=0 and `frame_n_i` high, `data_o` is 0.
- R9: `clear_n_i` low sets `code_o` to 0, and this wins over an update in the same cycle.
- R10: `binary_o` equals `code_o` when `twos_i`=0. When `twos_i`=1, it equals `code_o` with bit 11 inverted.
- R11: In load-strobe mode, a fall of `load_n_i` before the sixteenth bit has no effect on `code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, at least 4x the serial clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bit_clk_i | input | 1 | serial clock; data taken on its fall |
| data_i | input | 1 | serial data in |
| frame_n_i | input | 1 | active-low frame strobe |
| load_n_i | input | 1 | active-low load strobe / update mode select |
| clear_n_i | input | 1 | active-low latch clear |
| chain_i | input | 1 | 1 = chained (ungated), 0 = standalone |
| twos_i | input | 1 | 1 = two's complement input coding |
| data_o | output | 1 | serial data out (bit leaving the register) |
| code_o | output | 12 | latched converter code |
| binary_o | output | 12 | code in straight-binary form |

## Verification
Some properties are checked on every cycle. The bit counter never passes the frame length. The register holds while the frame strobe is high. The serial output stays low when idle in standalone use. A low clear zeroes the latch. The latch never moves without an update or clear. The low code bits pass through unchanged to `binary_o`.

Other behaviour can only be shown by the bench's scenarios. These are the frame format and the dropped top bits, and the gating after sixteen bits, which is seen through a later strobe load. They also cover the choice between automatic and strobe updates, and early strobe falls being ignored. The serial output ripple across two chained words and the clear winning over a load can likewise only be shown there.

// File: rtl/ser_dac_pkg.sv
package ser_dac_pkg;
   typedef struct packed {
      logic sclk;
      logic sdin;
      logic frame_n;
      logic load_n;
      logic clear_n;
      logic chain;
      logic twos;
   } pin_bus_t;

   localparam int PIN_W = $bits(pin_bus_t);

   localparam pin_bus_t PIN_IDLE = '{sclk: 1'b1, sdin: 1'b0, frame_n: 1'b1,
                                     load_n: 1'b1, clear_n: 1'b1,
                                     chain: 1'b0, twos: 1'b0};
endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
   parameter int              W      = 7,
   parameter int              STAGES = 2,
   parameter logic [W-1:0]    IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= IDLE;
      else        stg[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= IDLE;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sdf_shift.sv
module sdf_shift #(
   parameter int FRAME_W = 16,
   localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_fall,
   input  logic               frame_fall,
   input  logic               frame_low,
   input  logic               chain,
   input  logic               sdin,
   input  logic               load_n_lvl,
   output logic [FRAME_W-1:0] word_o,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               sdo_o,
   output logic               auto_done_o,
   output logic               full_o,
   output logic               auto_mode_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] TOP  = CNT_W'(FRAME_W);

   logic shift_ok;
   assign shift_ok = sclk_fall && frame_low && (chain || (cnt_o != TOP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o      <= '0;
         cnt_o       <= '0;
         sdo_o       <= 1'b0;
         auto_done_o <= 1'b0;
         full_o      <= 1'b0;
         auto_mode_o <= 1'b0;
      end else begin
         auto_done_o <= 1'b0;
         if (frame_fall) begin
            auto_mode_o <= !load_n_lvl;
            full_o      <= 1'b0;
         end
         if (!frame_low) begin
            cnt_o <= '0;
         end else if (shift_ok) begin
            word_o <= {word_o[FRAME_W-2:0], sdin};
            if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
            if (cnt_o == LAST) begin
               full_o      <= 1'b1;
               auto_done_o <= auto_mode_o;
            end
         end
         if (shift_ok)                sdo_o <= word_o[FRAME_W-1];
         else if (!frame_low && !chain) sdo_o <= 1'b0;
      end
   end
endmodule

// File: rtl/sdf_update.sv
module sdf_update #(
   parameter int FRAME_W = 16,
   parameter int CODE_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               auto_done,
   input  logic               load_fall,
   input  logic               auto_mode,
   input  logic               full,
   input  logic               clear_n_lvl,
   input  logic               twos,
   input  logic [FRAME_W-1:0] word,
   output logic               load_evt_o,
   output logic [CODE_W-1:0]  code_o,
   output logic [CODE_W-1:0]  binary_o
);
   assign load_evt_o = auto_done || (load_fall && !auto_mode && full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           code_o <= '0;
      else if (!clear_n_lvl) code_o <= '0;
      else if (load_evt_o)   code_o <= word[CODE_W-1:0];
   end

   if (CODE_W > 1) begin : g_wide
      assign binary_o = {code_o[CODE_W-1] ^ twos, code_o[CODE_W-2:0]};
   end else begin : g_narrow
      assign binary_o = code_o ^ twos;
   end
endmodule

// File: rtl/ser_dac_front.sv
module ser_dac_front
   import ser_dac_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk_i,
   input  logic              data_i,
   input  logic              frame_n_i,
   input  logic              load_n_i,
   input  logic              clear_n_i,
   input  logic              chain_i,
   input  logic              twos_i,
   output logic              data_o,
   output logic [CODE_W-1:0] code_o,
   output logic [CODE_W-1:0] binary_o
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   initial begin
      assert (FRAME_W >= CODE_W && CODE_W >= 1)
         else $fatal(1, "frame must hold the code");
      assert (SYNC_STAGES >= 2)
         else $fatal(1, "at least two synchronizer stages");
   end

   pin_bus_t pins_raw, pins_s, pins_q;
   assign pins_raw = '{sclk: bit_clk_i, sdin: data_i, frame_n: frame_n_i,
                       load_n: load_n_i, clear_n: clear_n_i,
                       chain: chain_i, twos: twos_i};

   sdf_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q <= PIN_IDLE;
      else        pins_q <= pins_s;
   end

   logic sclk_fall, frame_fall, load_fall, frame_low;
   assign sclk_fall  = pins_q.sclk    && !pins_s.sclk;
   assign frame_fall = pins_q.frame_n && !pins_s.frame_n;
   assign load_fall  = pins_q.load_n  && !pins_s.load_n;
   assign frame_low  = !pins_s.frame_n;

   logic [FRAME_W-1:0] word;
   logic [CNT_W-1:0]   cnt;
   logic               auto_done, full, auto_mode, load_evt;

   sdf_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .frame_fall(frame_fall),
      .frame_low(frame_low), .chain(pins_s.chain), .sdin(pins_s.sdin),
      .load_n_lvl(pins_s.load_n), .word_o(word), .cnt_o(cnt), .sdo_o(data_o),
      .auto_done_o(auto_done), .full_o(full), .auto_mode_o(auto_mode));

   sdf_update #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_update (
      .clk(clk), .rst_n(rst_n), .auto_done(auto_done), .load_fall(load_fall),
      .auto_mode(auto_mode), .full(full), .clear_n_lvl(pins_s.clear_n),
      .twos(pins_s.twos), .word(word), .load_evt_o(load_evt),
      .code_o(code_o), .binary_o(binary_o));
endmodule

// File: rtl/ser_dac_front_chk.sv
module ser_dac_front_chk #(
   parameter int FRAME_W = 16,
   parameter int CODE_W  = 12,
   localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_low,
   input logic               chain,
   input logic               clear_n_lvl,
   input logic               load_evt,
   input logic [CNT_W-1:0]   cnt,
   input logic [FRAME_W-1:0] word,
   input logic               sdo,
   input logic [CODE_W-1:0]  code,
   input logic [CODE_W-1:0]  binary
);
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(FRAME_W));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_low |=> $stable(word));

   p_sdo_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_low && !chain) |=> !sdo);

   p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_n_lvl |=> (code == '0));

   p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_n_lvl && !load_evt) |=> $stable(code));

   if (CODE_W > 1) begin : g_low
      p_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
         binary[CODE_W-2:0] == code[CODE_W-2:0]);
   end
endmodule

bind ser_dac_front ser_dac_front_chk #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_low(frame_low), .chain(pins_s.chain),
   .clear_n_lvl(pins_s.clear_n), .load_evt(load_evt), .cnt(cnt), .word(word),
   .sdo(data_o), .code(code_o), .binary(binary_o));

// File: tb/ser_dac_front_bench.sv
module ser_dac_front_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1, sdin = 1'b0, frame_n = 1'b1, load_n = 1'b1;
   logic clear_n = 1'b1, chain = 1'b0, twos = 1'b0;
   logic        sdo;
   logic [11:0] code, binv;
   int total = 0, bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ser_dac_front u_ser_dac_front (
      .clk(clk), .rst_n(rst_n), .bit_clk_i(sclk), .data_i(sdin),
      .frame_n_i(frame_n), .load_n_i(load_n), .clear_n_i(clear_n),
      .chain_i(chain), .twos_i(twos), .data_o(sdo), .code_o(code),
      .binary_o(binv));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [15:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sdin = w[i];
         tick(4);
         sclk = 1'b0;
         tick(4);
         sclk = 1'b1;
      end
   endtask

   task automatic frame_start(input logic ld);
      load_n = ld;
      tick(4);
      frame_n = 1'b0;
      tick(4);
   endtask

   task automatic frame_end();
      tick(4);
      frame_n = 1'b1;
      tick(6);
   endtask

   task automatic t_reset();
      check("R1 code", 16'(code), 16'h000);
      check("R1 binary", 16'(binv), 16'h000);
      check("R1 sdo", 16'(sdo), 16'h0);
   endtask

   task automatic t_auto();
      frame_start(1'b0);
      send_bits(16'hA5C3, 16);
      tick(6);
      check("R5 auto update at 16th bit", 16'(code), 16'h5C3);
      frame_end();
      check("R2 low 12 bits kept", 16'(code), 16'h5C3);
   endtask

   task automatic t_gate();
      frame_start(1'b1);
      send_bits(16'h1234, 16);
      send_bits(16'h000F, 4);
      frame_end();
      check("R6 no update without strobe", 16'(code), 16'h5C3);
      load_n = 1'b0;
      tick(6);
      check("R3 extra bits blocked", 16'(code), 16'h234);
      load_n = 1'b1;
      tick(4);
   endtask

   task automatic t_early_strobe();
      frame_start(1'b1);
      send_bits(16'h000A, 8);
      load_n = 1'b0;
      tick(6);
      load_n = 1'b1;
      tick(6);
      check("R11 early strobe ignored", 16'(code), 16'h234);
      send_bits(16'h00BC, 8);
      frame_end();
      check("R6 hold after frame", 16'(code), 16'h234);
      load_n = 1'b0;
      tick(6);
      check("R6 strobe load", 16'(code), 16'hABC);
   endtask

   task automatic t_idle_edges();
      load_n = 1'b1;
      tick(4);
      send_bits(16'hFFFF, 16);
      load_n = 1'b0;
      tick(6);
      check("R4 idle edges no shift", 16'(code), 16'hABC);
      load_n = 1'b1;
      tick(4);
   endtask

   task automatic t_coding();
      twos = 1'b1;
      tick(6);
      check("R10 twos binary", 16'(binv), 16'h2BC);
      check("R10 code unchanged", 16'(code), 16'hABC);
      twos = 1'b0;
      tick(6);
      check("R10 straight binary", 16'(binv), 16'hABC);
   endtask

   task automatic t_clear();
      clear_n = 1'b0;
      load_n = 1'b0;
      tick(6);
      check("R9 clear wins over load", 16'(code), 16'h000);
      clear_n = 1'b1;
      tick(6);
      check("R9 stays clear", 16'(code), 16'h000);
      load_n = 1'b1;
      tick(4);
   endtask

   task automatic t_chain();
      logic [15:0] first = 16'hC35B;
      logic [15:0] second = 16'h9E01;
      int misses = 0;
      chain = 1'b1;
      frame_start(1'b1);
      send_bits(first, 16);
      for (int k = 0; k < 16; k++) begin
         sdin = second[15 - k];
         tick(4);
         sclk = 1'b0;
         tick(4);
         if (sdo !== first[15 - k]) misses++;
         sclk = 1'b1;
      end
      check("R7 sdo ripple mismatches", 16'(misses), 16'h0);
      frame_end();
      load_n = 1'b0;
      tick(6);
      check("R7 second word loaded", 16'(code), 16'hE01);
      load_n = 1'b1;
      chain = 1'b0;
      tick(6);
      check("R8 sdo idle low", 16'(sdo), 16'h0);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_auto();
      t_gate();
      t_early_strobe();
      t_idle_edges();
      t_coding();
      t_clear();
      t_chain();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule